// File: doc/BRIEF.md
# Sequential Binary-to-Decimal Digit Converter

This block turns an unsigned binary word (16 bits by default) into four packed decimal digits. It uses the shift-and-add-3 method and handles one operand bit on each clock edge. It does not unroll the whole conversion into combinational logic. Each step first adds 3 to every digit nibble whose value is above 4. It then shifts the digit register left by one place, and the operand's most significant bit moves into the lowest digit bit. Because every digit stays within 0..9, the add-3 can never carry into the next digit. Each nibble therefore has its own small adjust cell.

A request is presented on a valid/ready pair. `in_ready` high means the converter is idle and will take the word on `in_data` at the next clock edge where `in_valid` is also high. While a conversion runs, `in_ready` stays low and `in_valid` is ignored. This acts as the block's busy indication, and no request is queued. The result side has no back-pressure. `out_valid` pulses for one cycle, and the digit outputs and the over-range flag then hold that result until the next conversion completes.

Top module: `b2d_seq_conv`

## Requirements
- R1: While the synchronous active-high reset `rst` is asserted, and after it is released, the outputs read `in_ready`=1, `out_valid`=0, `out_bcd`=0 and `out_ovf`=0 until a conversion completes.
- R2: A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the next cycle until the cycle after `out_valid`, and it is high again on the cycle after that.
- R3: `out_ovf` is set with `out_valid` exactly when the accepted word exceeds 9999 (0x270F). Otherwise it is cleared.
- R4: For an accepted word of 9999 or less, `out_bcd` holds the decimal digits thousands in [15:12], hundreds in [11:8], tens in [7:4] and ones in [3:0].
- R5: For an accepted word above 9999, `out_bcd` holds the low four decimal digits of the word, which is the word modulo 10000, in the same nibble order.
- R6: `out_valid` is high for exactly one cycle. That cycle is the 16th clock edge after the accepting edge, so the latency equals the operand width.
- R7: `in_valid` is ignored while `in_ready` is low. It neither changes the running result nor starts another conversion.
- R8: `out_bcd` and `out_ovf` change only together with `out_valid`. Otherwise they hold the last completed result, including during the next conversion.
- R9: Every accepted word starts from cleared digit state. A result never depends on the word converted before it.
- R10: Every nibble of `out_bcd` presented with `out_valid` lies in 0..9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request: `in_data` holds a word to convert |
| in_ready | output | 1 | Converter idle; a request is taken this cycle |
| in_data | input | 16 | Unsigned binary word |
| out_valid | output | 1 | One-cycle pulse: a new result is on `out_bcd`/`out_ovf` |
| out_bcd | output | 16 | Four decimal digits, thousands in the top nibble |
| out_ovf | output | 1 | Last accepted word was above 9999 |

## Verification
The hardest situation to reach from the ports is a request that arrives while a conversion is in flight. That attempt must be dropped without disturbing the running operand or causing a second result. The stimulus holds `in_valid` high, with a different word, for the whole busy window, including the done cycle. It then checks that the result matches the first word and that `in_ready` returns with no extra `out_valid`. The second hard case is leftover digit state: a maximal word is followed directly by zero and by small words, so any missing clear shows up as wrong digits. Random words from a fixed seed, together with directed digit-rollover and over-range boundaries, exercise the adjust cells against a reference computed with division and modulo.

// File: rtl/b2d_pkg.sv
package b2d_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } b2d_state_e;
endpackage

// File: rtl/b2d_adjust.sv
// Per-digit add-3 correction applied before each doubling step.
module b2d_adjust #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] bcd_i,
  output logic [4*DIGITS-1:0] bcd_o
);
  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [3:0] nib;
    assign nib = bcd_i[4*g +: 4];
    // digits stay in 0..9, so +3 never leaves the nibble
    assign bcd_o[4*g +: 4] = (nib > 4'd4) ? nib + 4'd3 : nib;
  end
endmodule

// File: rtl/b2d_ctrl.sv
// Iteration control: idle / shift / done sequencing and bit counter.
module b2d_ctrl
  import b2d_pkg::*;
#(
  parameter int BIN_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  output logic load,
  output logic step,
  output logic last
);
  localparam int CNT_W = (BIN_W > 1) ? $clog2(BIN_W) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(BIN_W - 1);

  b2d_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign in_ready = (state_q == ST_IDLE);
  assign load     = in_valid && in_ready;
  assign step     = (state_q == ST_SHIFT);
  assign last     = step && (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          state_d = ST_SHIFT;
          cnt_d   = CNT_TOP;
        end
      end
      ST_SHIFT: begin
        if (cnt_q == '0) state_d = ST_DONE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/b2d_seq_conv.sv
// Sequential binary to packed-decimal converter, one operand bit per clock.
module b2d_seq_conv #(
  parameter int BIN_W  = 16,
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [BIN_W-1:0]    in_data,
  output logic                out_valid,
  output logic [4*DIGITS-1:0] out_bcd,
  output logic                out_ovf
);
  localparam int BCD_W = 4 * DIGITS;
  localparam longint unsigned MAX_VAL = (longint'(10) ** DIGITS) - 1;

  logic load, step, last;
  logic [BIN_W-1:0] opnd_q;
  logic [BCD_W-1:0] bcd_q, bcd_adj, bcd_nxt;
  logic             ovf_pend_q, ovf_in;
  logic             out_valid_q, out_ovf_q;
  logic [BCD_W-1:0] out_bcd_q;

  b2d_ctrl #(.BIN_W(BIN_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .load     (load),
    .step     (step),
    .last     (last)
  );

  b2d_adjust #(.DIGITS(DIGITS)) u_adj (
    .bcd_i (bcd_q),
    .bcd_o (bcd_adj)
  );

  // adjust first, then double and bring in the next operand bit
  assign bcd_nxt = {bcd_adj[BCD_W-2:0], opnd_q[BIN_W-1]};
  assign ovf_in  = (64'(in_data) > MAX_VAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      opnd_q     <= '0;
      bcd_q      <= '0;
      ovf_pend_q <= 1'b0;
    end else if (load) begin
      opnd_q     <= in_data;
      bcd_q      <= '0;
      ovf_pend_q <= ovf_in;
    end else if (step) begin
      opnd_q     <= {opnd_q[BIN_W-2:0], 1'b0};
      bcd_q      <= bcd_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_q <= 1'b0;
      out_bcd_q   <= '0;
      out_ovf_q   <= 1'b0;
    end else begin
      out_valid_q <= last;
      if (last) begin
        out_bcd_q <= bcd_nxt;
        out_ovf_q <= ovf_pend_q;
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_bcd   = out_bcd_q;
  assign out_ovf   = out_ovf_q;
endmodule

// File: rtl/b2d_seq_conv_chk.sv
// Temporal checks on the converter ports, attached by bind.
module b2d_seq_conv_chk #(
  parameter int BIN_W  = 16,
  parameter int DIGITS = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic [BIN_W-1:0]    in_data,
  input logic                out_valid,
  input logic [4*DIGITS-1:0] out_bcd,
  input logic                out_ovf
);
  localparam int LAT_W = $clog2(BIN_W + 1) + 1;
  localparam longint unsigned MAX_VAL = (longint'(10) ** DIGITS) - 1;

  logic [LAT_W-1:0] lat_q;
  logic             ovf_exp_q;
  logic             bad_dig;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q     <= '0;
      ovf_exp_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      lat_q     <= '0;
      ovf_exp_q <= (64'(in_data) > MAX_VAL);
    end else if (!in_ready) begin
      lat_q     <= lat_q + 1'b1;
    end
  end

  always_comb begin
    bad_dig = 1'b0;
    for (int i = 0; i < DIGITS; i++)
      if (out_bcd[4*i +: 4] > 4'd9) bad_dig = 1'b1;
  end

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  p_ovf_flag_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_ovf == ovf_exp_q));

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (lat_q == LAT_W'(BIN_W)));

  p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_bcd) && $stable(out_ovf)));

  p_digit_range_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !bad_dig);
endmodule

bind b2d_seq_conv b2d_seq_conv_chk #(.BIN_W(BIN_W), .DIGITS(DIGITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_bcd   (out_bcd),
  .out_ovf   (out_ovf)
);

// File: tb/tb_b2d_seq_conv.sv
module tb_b2d_seq_conv;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [15:0] out_bcd;
  logic        out_ovf;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] last_bcd = '0;
  logic        last_ovf = 1'b0;

  always #2.5 clk = ~clk;

  b2d_seq_conv dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_bcd(out_bcd), .out_ovf(out_ovf)
  );

  function automatic logic [15:0] ref_bcd(input int unsigned v);
    int unsigned m = v % 10000;
    return {4'(m / 1000), 4'((m / 100) % 10), 4'((m / 10) % 10), 4'(m % 10)};
  endfunction

  function automatic bit digits_ok(input logic [15:0] b);
    for (int i = 0; i < 4; i++) if (b[4*i +: 4] > 4'd9) return 0;
    return 1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic convert(input logic [15:0] v, input bit hold_req,
                         input logic [15:0] junk, input string req);
    int k;
    logic [15:0] exp_b;
    bit exp_o;
    exp_b = ref_bcd(v);
    exp_o = (v > 16'd9999);
    chk(in_ready === 1'b1, "R2", "ready before request", int'(in_ready), 1);
    in_data  = v;
    in_valid = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b0, "R2", "busy after accept", int'(in_ready), 0);
    if (hold_req) in_data = junk;
    else          in_valid = 1'b0;
    k = 1;
    while (out_valid !== 1'b1 && k < 40) begin
      chk(out_bcd === last_bcd && out_ovf === last_ovf, "R8", "hold old result",
          int'(out_bcd), int'(last_bcd));
      @(negedge clk);
      k++;
    end
    chk(k == 17, "R6", "latency in cycles", k, 17);
    chk(out_bcd === exp_b, exp_o ? "R5" : "R4", "digits", int'(out_bcd), int'(exp_b));
    chk(out_ovf === exp_o, "R3", "overflow flag", int'(out_ovf), int'(exp_o));
    chk(digits_ok(out_bcd), "R10", "digit range", int'(out_bcd), int'(exp_b));
    chk(in_ready === 1'b0, "R2", "busy during done", int'(in_ready), 0);
    if (req != "") chk(out_bcd === exp_b, req, "directed case", int'(out_bcd), int'(exp_b));
    in_valid = 1'b0;
    last_bcd = exp_b;
    last_ovf = exp_o;
    @(negedge clk);
    chk(out_valid === 1'b0, "R6", "pulse width", int'(out_valid), 0);
    chk(in_ready === 1'b1, hold_req ? "R7" : "R2", "ready returns", int'(in_ready), 1);
    chk(out_bcd === last_bcd && out_ovf === last_ovf, "R8", "result held",
        int'(out_bcd), int'(last_bcd));
  endtask

  initial begin
    int unsigned seed_val;
    logic [15:0] v;
    seed_val = $urandom(32'd24681);
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R1", "ctrl in reset",
        int'({in_ready, out_valid}), 2);
    chk(out_bcd === 16'h0 && out_ovf === 1'b0, "R1", "data in reset", int'(out_bcd), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0 && out_bcd === 16'h0, "R1",
        "after release", int'(out_bcd), 0);
    // idle cycles with no request: nothing happens
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && out_bcd === 16'h0, "R8", "idle hold", int'(out_bcd), 0);

    convert(16'd0,     0, 16'd0, "R4");
    convert(16'd1,     0, 16'd0, "R4");
    convert(16'd9,     0, 16'd0, "R4");
    convert(16'd10,    0, 16'd0, "R4");
    convert(16'd99,    0, 16'd0, "R4");
    convert(16'd100,   0, 16'd0, "R4");
    convert(16'd999,   0, 16'd0, "R4");
    convert(16'd1000,  0, 16'd0, "R4");
    convert(16'd9999,  0, 16'd0, "R3");
    convert(16'd10000, 0, 16'd0, "R5");
    convert(16'd65535, 0, 16'd0, "R5");
    convert(16'd0,     0, 16'd0, "R9");
    convert(16'd65535, 0, 16'd0, "R5");
    convert(16'd7,     0, 16'd0, "R9");
    convert(16'd1234,  1, 16'd65535, "R7");
    convert(16'd40000, 1, 16'd3, "R7");
    convert(16'd5,     1, 16'd9999, "R7");

    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(3, 0) == 0) v = 16'($urandom_range(65535, 0));
      else                           v = 16'($urandom_range(9999, 0));
      convert(v, ($urandom_range(7, 0) == 0), 16'($urandom_range(65535, 0)), "");
      repeat ($urandom_range(2, 0)) begin
        @(negedge clk);
        chk(out_valid === 1'b0 && out_bcd === last_bcd, "R8", "gap hold",
            int'(out_bcd), int'(last_bcd));
      end
    end

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule